// File: doc/BRIEF.md
# Endpoint Interrupt Message Controller

This block turns interrupt activity on the endpoint side into message requests for a transaction layer. A legacy level input is watched for edges. Each rising edge becomes an assert-INTA request and each falling edge becomes a deassert-INTA request. An acknowledge pulse comes back once the transaction layer has taken that request. Internal events (system error, hot plug or power management) and application MSI requests are turned into an MSI vector number and a traffic class. The vector depends on how many MSI vectors the host has allocated.

All requests leave through one valid/ready port that carries a message kind, a vector and a traffic class. Only one request is presented at a time, and a fixed priority picks the next one. Building the packet, the configuration space and the link are handled elsewhere.

Top module: `irq_msg_ctrl`

## Requirements
- R1: A synchronous active-high `rst` drops every pending request, clears `msg_valid` and `leg_ack`, and returns the legacy state to deasserted. No message is sent because of the reset.
- R2: A rising `leg_level` produces exactly one message of kind 1 (assert-INTA). A falling `leg_level` produces exactly one message of kind 2 (deassert-INTA). Kind 0 is an MSI.
- R3: `leg_ack` is high for one cycle in the cycle after a legacy message is handshaken (`msg_valid` and `msg_ready` both high). It is never high otherwise.
- R4: With `alloc_mode` 2'b00 (32 vectors), a system error uses vector 31 and a hot plug/power management event uses vector 30. Application vectors above 29 saturate to 29.
- R5: With `alloc_mode` 2'b01 (four vectors, split), a system error uses vector 3 and a hot plug/power management event uses vector 2. Application vectors above 1 saturate to 1.
- R6: With `alloc_mode` 2'b10 or 2'b11 (four vectors, shared), both internal events use vector 3. Application vectors above 2 saturate to 2.
- R7: Internal-event MSIs carry traffic class 0. An application MSI carries the `app_msi_tc` value captured with its request. Legacy messages carry vector 0 and class 0.
- R8: Among pending requests the next one presented is chosen in this order: system error, hot plug/power management, application MSI, legacy message.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_kind`, `msg_vec` and `msg_tc` hold their values.
- R10: Legacy messages strictly alternate, starting with assert-INTA after reset. A level pulse that starts and ends while the output is busy with other traffic produces no legacy message.
- R11: A new application request that arrives while an earlier one is still pending (not yet presented) is ignored.
- R12: A request pulse or level change sampled at clock edge k is presented on the output after edge k+1 when the output is free and nothing of higher priority is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_mode | input | 2 | Static MSI allocation mode (00 = 32, 01 = 4 split, 1x = 4 shared) |
| leg_level | input | 1 | Legacy interrupt level from the application |
| leg_ack | output | 1 | One-cycle pulse after a legacy message is taken |
| sys_err_req | input | 1 | System error event pulse |
| hp_pm_req | input | 1 | Hot plug / power management event pulse |
| app_msi_req | input | 1 | Application MSI request pulse |
| app_msi_vec | input | 5 | Application MSI vector number |
| app_msi_tc | input | 3 | Application MSI traffic class |
| msg_valid | output | 1 | Outgoing message request valid |
| msg_ready | input | 1 | Transaction layer accepts the message |
| msg_kind | output | 2 | 0 = MSI, 1 = assert-INTA, 2 = deassert-INTA |
| msg_vec | output | 5 | MSI vector number |
| msg_tc | output | 3 | Traffic class |

## Verification
A request pulse or level change sampled at a rising edge sets internal state at that edge. It shows up on the output after the following edge, so the bench drives on a falling edge and checks the message two falling edges later. A handshake takes place at the rising edge inside a one-cycle window where `msg_ready` is high. The next queued message and `leg_ack` are then visible at the very next falling edge, and that is where they are checked. The pulse is checked to be gone one falling edge after that. Stability checks sample over several falling edges while `msg_ready` stays low.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    typedef enum logic [1:0] {
        MK_MSI      = 2'd0,
        MK_ASSERT   = 2'd1,
        MK_DEASSERT = 2'd2
    } msg_kind_e;

    localparam logic [1:0] ALLOC_FULL  = 2'd0;
    localparam logic [1:0] ALLOC_SPLIT = 2'd1;

endpackage

// File: rtl/irq_msi_map.sv
module irq_msi_map
    import irq_msg_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic [1:0]       alloc_mode,
    input  logic [VEC_W-1:0] app_vec_in,
    output logic [VEC_W-1:0] sys_vec,
    output logic [VEC_W-1:0] hp_vec,
    output logic [VEC_W-1:0] app_vec_out
);

    localparam int FULL_N = 1 << VEC_W;

    logic [VEC_W-1:0] app_top;

    always_comb begin
        if (alloc_mode == ALLOC_FULL) begin
            sys_vec = VEC_W'(FULL_N - 1);
            hp_vec  = VEC_W'(FULL_N - 2);
            app_top = VEC_W'(FULL_N - 3);
        end else if (alloc_mode == ALLOC_SPLIT) begin
            sys_vec = VEC_W'(3);
            hp_vec  = VEC_W'(2);
            app_top = VEC_W'(1);
        end else begin
            sys_vec = VEC_W'(3);
            hp_vec  = VEC_W'(3);
            app_top = VEC_W'(2);
        end
        app_vec_out = (app_vec_in > app_top) ? app_top : app_vec_in;
    end

    // R4 R5 R6: application vectors never reach the internal-event vectors
    always_comb begin
        a_r6_app_below_events: assert (app_vec_out < hp_vec || alloc_mode[1]);
    end

endmodule

// File: rtl/irq_legacy_trk.sv
module irq_legacy_trk (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    input  logic grant,
    input  logic done,
    output logic want,
    output logic want_assert,
    output logic ack
);

    typedef struct packed {
        logic lvl;
        logic issued;
        logic ack;
    } leg_st_t;

    leg_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.lvl    = level_in;
        st_d.ack    = done;
        if (grant) begin
            st_d.issued = ~st_q.issued;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign want        = st_q.lvl != st_q.issued;
    assign want_assert = ~st_q.issued;
    assign ack         = st_q.ack;

    a_r3_ack_follows_send: assert property (@(posedge clk) disable iff (rst)
        st_q.ack |-> $past(done));

    a_r10_grant_needs_change: assert property (@(posedge clk) disable iff (rst)
        grant |-> want);

endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
    import irq_msg_pkg::*;
#(
    parameter int VEC_W = 5,
    parameter int TC_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sys_req,
    input  logic             hp_req,
    input  logic             app_req,
    input  logic [VEC_W-1:0] sys_vec,
    input  logic [VEC_W-1:0] hp_vec,
    input  logic [VEC_W-1:0] app_vec,
    input  logic [TC_W-1:0]  app_tc,
    input  logic             leg_want,
    input  logic             leg_assert,
    output logic             leg_grant,
    output logic             leg_done,
    input  logic             msg_ready,
    output logic             msg_valid,
    output logic [1:0]       msg_kind,
    output logic [VEC_W-1:0] msg_vec,
    output logic [TC_W-1:0]  msg_tc
);

    typedef struct packed {
        logic             pend_sys;
        logic             pend_hp;
        logic             pend_app;
        logic [VEC_W-1:0] app_vec;
        logic [TC_W-1:0]  app_tc;
        logic             o_valid;
        msg_kind_e        o_kind;
        logic [VEC_W-1:0] o_vec;
        logic [TC_W-1:0]  o_tc;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    load;
    logic    hs;

    always_comb begin
        st_d      = st_q;
        leg_grant = 1'b0;
        hs        = st_q.o_valid && msg_ready;
        load      = !st_q.o_valid || msg_ready;

        if (load) begin
            st_d.o_valid = 1'b0;
            st_d.o_kind  = MK_MSI;
            st_d.o_vec   = '0;
            st_d.o_tc    = '0;
            if (st_q.pend_sys) begin
                st_d.o_valid  = 1'b1;
                st_d.o_vec    = sys_vec;
                st_d.pend_sys = 1'b0;
            end else if (st_q.pend_hp) begin
                st_d.o_valid = 1'b1;
                st_d.o_vec   = hp_vec;
                st_d.pend_hp = 1'b0;
            end else if (st_q.pend_app) begin
                st_d.o_valid  = 1'b1;
                st_d.o_vec    = st_q.app_vec;
                st_d.o_tc     = st_q.app_tc;
                st_d.pend_app = 1'b0;
            end else if (leg_want) begin
                st_d.o_valid = 1'b1;
                st_d.o_kind  = leg_assert ? MK_ASSERT : MK_DEASSERT;
                leg_grant    = 1'b1;
            end
        end

        if (sys_req) begin
            st_d.pend_sys = 1'b1;
        end
        if (hp_req) begin
            st_d.pend_hp = 1'b1;
        end
        if (app_req && !st_q.pend_app) begin
            st_d.pend_app = 1'b1;
            st_d.app_vec  = app_vec;
            st_d.app_tc   = app_tc;
        end

        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign leg_done  = hs && (st_q.o_kind != MK_MSI);
    assign msg_valid = st_q.o_valid;
    assign msg_kind  = st_q.o_kind;
    assign msg_vec   = st_q.o_vec;
    assign msg_tc    = st_q.o_tc;

    // checker state: kind of the last legacy message taken
    logic last_leg_assert_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            last_leg_assert_q <= 1'b0;
        end else if (leg_done) begin
            last_leg_assert_q <= (st_q.o_kind == MK_ASSERT);
        end
    end

    a_r9_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=>
            (msg_valid && $stable(msg_kind) && $stable(msg_vec) && $stable(msg_tc)));

    a_r10_no_double_assert: assert property (@(posedge clk) disable iff (rst)
        (leg_done && msg_kind == MK_ASSERT) |-> !last_leg_assert_q);

    a_r10_no_orphan_deassert: assert property (@(posedge clk) disable iff (rst)
        (leg_done && msg_kind == MK_DEASSERT) |-> last_leg_assert_q);

    a_r7_legacy_fields_zero: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind != MK_MSI) |-> (msg_vec == '0 && msg_tc == '0));

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !msg_valid);

endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
    import irq_msg_pkg::*;
#(
    parameter int VEC_W = 5,
    parameter int TC_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       alloc_mode,
    input  logic             leg_level,
    output logic             leg_ack,
    input  logic             sys_err_req,
    input  logic             hp_pm_req,
    input  logic             app_msi_req,
    input  logic [VEC_W-1:0] app_msi_vec,
    input  logic [TC_W-1:0]  app_msi_tc,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [1:0]       msg_kind,
    output logic [VEC_W-1:0] msg_vec,
    output logic [TC_W-1:0]  msg_tc
);

    logic [VEC_W-1:0] sys_vec, hp_vec, app_vec_m;
    logic             leg_want, leg_want_assert, leg_grant, leg_done;

    irq_msi_map #(.VEC_W(VEC_W)) i_map (
        .alloc_mode  (alloc_mode),
        .app_vec_in  (app_msi_vec),
        .sys_vec     (sys_vec),
        .hp_vec      (hp_vec),
        .app_vec_out (app_vec_m)
    );

    irq_legacy_trk i_leg (
        .clk         (clk),
        .rst         (rst),
        .level_in    (leg_level),
        .grant       (leg_grant),
        .done        (leg_done),
        .want        (leg_want),
        .want_assert (leg_want_assert),
        .ack         (leg_ack)
    );

    irq_msg_arb #(.VEC_W(VEC_W), .TC_W(TC_W)) i_arb (
        .clk        (clk),
        .rst        (rst),
        .sys_req    (sys_err_req),
        .hp_req     (hp_pm_req),
        .app_req    (app_msi_req),
        .sys_vec    (sys_vec),
        .hp_vec     (hp_vec),
        .app_vec    (app_vec_m),
        .app_tc     (app_msi_tc),
        .leg_want   (leg_want),
        .leg_assert (leg_want_assert),
        .leg_grant  (leg_grant),
        .leg_done   (leg_done),
        .msg_ready  (msg_ready),
        .msg_valid  (msg_valid),
        .msg_kind   (msg_kind),
        .msg_vec    (msg_vec),
        .msg_tc     (msg_tc)
    );

endmodule

// File: tb/test_irq_msg_ctrl.sv
module test_irq_msg_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] alloc_mode = 2'd0;
    logic       leg_level = 1'b0;
    logic       leg_ack;
    logic       sys_err_req = 1'b0;
    logic       hp_pm_req = 1'b0;
    logic       app_msi_req = 1'b0;
    logic [4:0] app_msi_vec = '0;
    logic [2:0] app_msi_tc = '0;
    logic       msg_valid;
    logic       msg_ready = 1'b0;
    logic [1:0] msg_kind;
    logic [4:0] msg_vec;
    logic [2:0] msg_tc;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_msg_ctrl i_irq_msg_ctrl (
        .clk(clk), .rst(rst), .alloc_mode(alloc_mode),
        .leg_level(leg_level), .leg_ack(leg_ack),
        .sys_err_req(sys_err_req), .hp_pm_req(hp_pm_req),
        .app_msi_req(app_msi_req), .app_msi_vec(app_msi_vec), .app_msi_tc(app_msi_tc),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_kind(msg_kind), .msg_vec(msg_vec), .msg_tc(msg_tc)
    );

    function automatic int exp_sys(int m);
        return (m == 0) ? 31 : 3;
    endfunction
    function automatic int exp_hp(int m);
        return (m == 0) ? 30 : ((m == 1) ? 2 : 3);
    endfunction
    function automatic int exp_app(int m, int v);
        int top;
        top = (m == 0) ? 29 : ((m == 1) ? 1 : 2);
        return (v > top) ? top : v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_msg(input int k, input int v, input int t, input string req);
        int act, exp;
        act = {msg_valid, msg_kind, msg_vec, msg_tc};
        exp = {1'b1, k[1:0], v[4:0], t[2:0]};
        chk(act == exp, req, "message {valid,kind,vec,tc}", act, exp);
    endtask

    task automatic expect_idle(input string req);
        chk(msg_valid == 1'b0, req, "msg_valid idle", int'(msg_valid), 0);
    endtask

    task automatic take();
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state under reset
        expect_idle("R1");
        chk(leg_ack == 1'b0, "R1", "leg_ack in reset", int'(leg_ack), 0);
        rst = 1'b0;
        @(negedge clk);
        expect_idle("R1");

        // R4 R5 R6 R7 R12: internal events per mode
        for (int m = 0; m < 4; m++) begin
            alloc_mode = m[1:0];
            sys_err_req = 1'b1;
            @(negedge clk);
            sys_err_req = 1'b0;
            @(negedge clk);
            expect_msg(0, exp_sys(m), 0, "R4/R5/R6 sys R7 R12");
            take();
            expect_idle("R12");
            hp_pm_req = 1'b1;
            @(negedge clk);
            hp_pm_req = 1'b0;
            @(negedge clk);
            expect_msg(0, exp_hp(m), 0, "R4/R5/R6 hp R7");
            take();
            expect_idle("R12");
        end

        // R4 R5 R6 R7: application vector sweep per mode
        for (int m = 0; m < 4; m++) begin
            alloc_mode = m[1:0];
            for (int v = 0; v < 32; v++) begin
                app_msi_vec = v[4:0];
                app_msi_tc  = 3'((v + m) % 8);
                app_msi_req = 1'b1;
                @(negedge clk);
                app_msi_req = 1'b0;
                @(negedge clk);
                expect_msg(0, exp_app(m, v), (v + m) % 8, "R4/R5/R6 app R7");
                take();
                expect_idle("R7");
            end
        end

        // R8 R9 R11 R2 R3: everything at once, output stalled
        alloc_mode  = 2'd0;
        sys_err_req = 1'b1;
        hp_pm_req   = 1'b1;
        app_msi_req = 1'b1;
        app_msi_vec = 5'd5;
        app_msi_tc  = 3'd6;
        leg_level   = 1'b1;
        @(negedge clk);
        sys_err_req = 1'b0;
        hp_pm_req   = 1'b0;
        app_msi_req = 1'b0;
        @(negedge clk);
        expect_msg(0, 31, 0, "R8 sys first");
        app_msi_req = 1'b1;
        app_msi_vec = 5'd9;
        app_msi_tc  = 3'd1;
        @(negedge clk);
        app_msi_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            expect_msg(0, 31, 0, "R9 held");
            @(negedge clk);
        end
        chk(leg_ack == 1'b0, "R3", "leg_ack before send", int'(leg_ack), 0);
        take();
        expect_msg(0, 30, 0, "R8 hp second");
        take();
        expect_msg(0, 5, 6, "R8 app third R11");
        take();
        expect_msg(1, 0, 0, "R8 legacy last R2");
        chk(leg_ack == 1'b0, "R3", "leg_ack while pending", int'(leg_ack), 0);
        take();
        chk(leg_ack == 1'b1, "R3", "leg_ack after assert sent", int'(leg_ack), 1);
        expect_idle("R11 second app dropped");
        @(negedge clk);
        chk(leg_ack == 1'b0, "R3", "leg_ack one cycle", int'(leg_ack), 0);

        // R2 R3: falling level
        leg_level = 1'b0;
        @(negedge clk);
        @(negedge clk);
        expect_msg(2, 0, 0, "R2 deassert");
        take();
        chk(leg_ack == 1'b1, "R3", "leg_ack after deassert sent", int'(leg_ack), 1);
        expect_idle("R2");
        @(negedge clk);
        chk(leg_ack == 1'b0, "R3", "leg_ack drops", int'(leg_ack), 0);

        // R10: quick toggle while idle still gives assert then deassert
        leg_level = 1'b1;
        @(negedge clk);
        leg_level = 1'b0;
        @(negedge clk);
        expect_msg(1, 0, 0, "R10 assert first");
        take();
        expect_msg(2, 0, 0, "R10 deassert follows");
        take();
        expect_idle("R10");

        // R10: level pulse hidden behind busy output gives no message
        sys_err_req = 1'b1;
        @(negedge clk);
        sys_err_req = 1'b0;
        leg_level = 1'b1;
        @(negedge clk);
        leg_level = 1'b0;
        @(negedge clk);
        @(negedge clk);
        expect_msg(0, 31, 0, "R10 busy");
        take();
        expect_idle("R10 hidden pulse");
        @(negedge clk);
        expect_idle("R10 hidden pulse");
        chk(leg_ack == 1'b0, "R10", "no ack for hidden pulse", int'(leg_ack), 0);

        // R1: reset drops pending work
        sys_err_req = 1'b1;
        hp_pm_req   = 1'b1;
        @(negedge clk);
        sys_err_req = 1'b0;
        hp_pm_req   = 1'b0;
        @(negedge clk);
        expect_msg(0, 31, 0, "R1 before reset");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_idle("R1 after reset");
        for (int i = 0; i < 3; i++) begin
            msg_ready = 1'b1;
            @(negedge clk);
            expect_idle("R1 pending dropped");
        end
        msg_ready = 1'b0;

        finish_run();
    end

endmodule